// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps an effective address onto a real address through a small bank of block-translation entries. Two banks exist: one serves instruction fetches and the other serves data accesses. The request's side input chooses the bank. Each entry covers a power-of-two region. It holds a base compared under a mask, a real base, a user-mode enable, a supervisor-mode enable and a 2-bit protection code. A miss tells the surrounding logic that a page-table walk is needed.

Software loads entries one at a time through a simple write port. Lookups use a request/response handshake controlled by a two-state machine. In state `ST_IDLE`, `req_ready` is high. When a request is accepted (`req_valid && req_ready`), the search runs combinationally on the request inputs. Its result is registered and the machine moves to `ST_RESP` (transition *accept*). In `ST_RESP`, `rsp_valid` is high and the result is held. When `rsp_ready` is seen, the machine returns to `ST_IDLE` (transition *release*). If neither event occurs, the machine stays in its current state (transitions *wait_req* and *hold_rsp*).

The search does not stop at an entry that matches but refuses the access. It goes on to the next index, and the lowest-indexed usable entry wins.

Top module: `batu_top`

## Requirements
- R1: After reset every entry is disabled, so a lookup misses until software programs an entry. Out of reset `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_data_side`=0 searches only the instruction bank and 1 searches only the data bank. `cfg_side` uses the same encoding to choose which bank a write goes to.
- R3: With `req_user`=1 an entry takes part only if its user enable is set. With `req_user`=0 it takes part only if its supervisor enable is set.
- R4: An entry matches when `(req_ea & mask) == base`.
- R5: On a hit, `rsp_raddr` = real base OR `(req_ea & ~mask)`.
- R6: On a hit, read is granted when the protection code is nonzero, write is granted when the code is 2 or 3, and execute is always granted.
- R7: A matching entry with code 0 is skipped. A matching entry with code 1 is skipped for a write request. In both cases the search continues with higher indices.
- R8: Among usable entries, the lowest index wins.
- R9: A miss returns `rsp_hit`=0, `rsp_raddr`=0 and all permission flags 0.
- R10: An accepted request gives `rsp_valid`=1 on the next cycle. The response stays stable, and `req_ready` stays 0, until a cycle with `rsp_ready`=1.
- R11: A write with `cfg_we`=1 replaces entry `cfg_idx` of the chosen bank at the clock edge. Later lookups see the new content, and entries that were not addressed keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can accept a request |
| req_data_side | input | 1 | 0 = instruction bank, 1 = data bank |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_write | input | 1 | Request is a store |
| req_ea | input | EA_W | Effective address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_hit | output | 1 | A usable entry was found |
| rsp_raddr | output | EA_W | Translated real address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| cfg_we | input | 1 | Entry write strobe |
| cfg_side | input | 1 | Bank to write, same encoding as req_data_side |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_base | input | EA_W | Compare base |
| cfg_mask | input | EA_W | Compare mask |
| cfg_rbase | input | EA_W | Real base |
| cfg_user_ok | input | 1 | User-mode enable |
| cfg_sup_ok | input | 1 | Supervisor-mode enable |
| cfg_prot | input | 2 | Protection code |

## Verification
The assertions check the following on every cycle:
- the handshake: a response follows each acceptance, and a pending response is held stable with the ready output low;
- consistency of the permission flags: a hit is always readable, a write hit is always writable, and a miss has no flags and a zero address;
- that an entry changes only when it is written.

Only the bench scenarios can show which entry wins the search. That covers mode gating, skipping of refusing entries, lowest-index priority, separation of the two banks and the exact real-address merge. These scenarios compare results against hand-computed addresses for a programmed set of overlapping entries.

// File: rtl/batu_pkg.sv
package batu_pkg;
    parameter int BATU_EA_W = 32;
    parameter int BATU_PROT_W = 2;

    typedef struct packed {
        logic [BATU_EA_W-1:0]   base;
        logic [BATU_EA_W-1:0]   mask;
        logic [BATU_EA_W-1:0]   rbase;
        logic                   user_ok;
        logic                   sup_ok;
        logic [BATU_PROT_W-1:0] prot;
    } batu_entry_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } batu_state_e;
endpackage

// File: rtl/batu_bank.sv
module batu_bank
    import batu_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  batu_entry_t             wdata,
    output batu_entry_t [N_ENT-1:0] entries
);
    batu_entry_t [N_ENT-1:0] ent_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else if (we) begin
            ent_q[idx] <= wdata;
        end
    end

    assign entries = ent_q;

    // R11: untouched when not written; written slot takes the new value
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(ent_q));
    p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ent_q[$past(idx)] == $past(wdata));
endmodule

// File: rtl/batu_search.sv
module batu_search
    import batu_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  batu_entry_t [N_ENT-1:0] entries,
    input  logic [BATU_EA_W-1:0]    ea,
    input  logic                    user,
    input  logic                    write,
    output logic                    hit,
    output logic [BATU_EA_W-1:0]    raddr,
    output logic                    rd,
    output logic                    wr
);
    logic [N_ENT-1:0] usable;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic mode_ok, addr_ok, rd_ok, wr_ok;
        assign mode_ok = user ? entries[i].user_ok : entries[i].sup_ok;
        assign addr_ok = (ea & entries[i].mask) == entries[i].base;
        assign rd_ok   = entries[i].prot != '0;
        assign wr_ok   = entries[i].prot > 2'd1;
        assign usable[i] = mode_ok && addr_ok && rd_ok && (!write || wr_ok);
    end

    always_comb begin
        hit   = 1'b0;
        raddr = '0;
        rd    = 1'b0;
        wr    = 1'b0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (usable[i]) begin
                hit   = 1'b1;
                raddr = entries[i].rbase | (ea & ~entries[i].mask);
                rd    = entries[i].prot != '0;
                wr    = entries[i].prot > 2'd1;
            end
        end
    end

    // R6/R7: a chosen entry is always readable, and writable for a store
    always_comb begin
        if (hit) a_hit_readable_r6: assert (rd);
        if (hit && write) a_store_writable_r7: assert (wr);
    end
endmodule

// File: rtl/batu_top.sv
module batu_top
    import batu_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int EA_W = BATU_EA_W,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_data_side,
    input  logic             req_user,
    input  logic             req_write,
    input  logic [EA_W-1:0]  req_ea,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             rsp_hit,
    output logic [EA_W-1:0]  rsp_raddr,
    output logic             rsp_rd,
    output logic             rsp_wr,
    output logic             rsp_ex,
    input  logic             cfg_we,
    input  logic             cfg_side,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [EA_W-1:0]  cfg_base,
    input  logic [EA_W-1:0]  cfg_mask,
    input  logic [EA_W-1:0]  cfg_rbase,
    input  logic             cfg_user_ok,
    input  logic             cfg_sup_ok,
    input  logic [1:0]       cfg_prot
);
    batu_entry_t             wdata;
    batu_entry_t [N_ENT-1:0] bank_ent [2];
    batu_entry_t [N_ENT-1:0] sel_ent;

    assign wdata = '{base: cfg_base, mask: cfg_mask, rbase: cfg_rbase,
                     user_ok: cfg_user_ok, sup_ok: cfg_sup_ok, prot: cfg_prot};

    for (genvar s = 0; s < 2; s++) begin : g_bank
        batu_bank #(.N_ENT(N_ENT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (cfg_we && (cfg_side == s[0])),
            .idx     (cfg_idx),
            .wdata   (wdata),
            .entries (bank_ent[s])
        );
    end

    assign sel_ent = req_data_side ? bank_ent[1] : bank_ent[0];

    logic            s_hit, s_rd, s_wr;
    logic [EA_W-1:0] s_raddr;

    batu_search #(.N_ENT(N_ENT)) u_search (
        .entries (sel_ent),
        .ea      (req_ea),
        .user    (req_user),
        .write   (req_write),
        .hit     (s_hit),
        .raddr   (s_raddr),
        .rd      (s_rd),
        .wr      (s_wr)
    );

    batu_state_e state_q, state_d;
    logic        accept;

    assign accept = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;   // accept
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;   // release
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_raddr <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_ex    <= 1'b0;
        end else if (accept) begin
            rsp_hit   <= s_hit;
            rsp_raddr <= s_raddr;
            rsp_rd    <= s_rd;
            rsp_wr    <= s_wr;
            rsp_ex    <= s_hit;
        end
    end

    p_accept_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    p_hold_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && !req_ready && $stable(rsp_raddr)
                                    && $stable(rsp_hit) && $stable(rsp_rd) && $stable(rsp_wr));
    p_miss_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> rsp_raddr == '0 && !rsp_rd && !rsp_wr && !rsp_ex);
    p_perm_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> rsp_rd && rsp_ex && (!rsp_wr || rsp_rd));
endmodule

// File: tb/test_batu_top.sv
module test_batu_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_data_side = 1'b0, req_user = 1'b0, req_write = 1'b0;
    logic [31:0] req_ea = '0;
    logic        rsp_ready = 1'b0;
    logic        req_ready, rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
    logic [31:0] rsp_raddr;
    logic        cfg_we = 1'b0, cfg_side = 1'b0, cfg_user_ok = 1'b0, cfg_sup_ok = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0, cfg_mask = '0, cfg_rbase = '0;
    logic [1:0]  cfg_prot = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    batu_top i_batu_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_data_side(req_data_side),
        .req_user(req_user), .req_write(req_write), .req_ea(req_ea),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
        .rsp_raddr(rsp_raddr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
        .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_mask(cfg_mask), .cfg_rbase(cfg_rbase), .cfg_user_ok(cfg_user_ok),
        .cfg_sup_ok(cfg_sup_ok), .cfg_prot(cfg_prot)
    );

    typedef struct packed {
        logic        side;
        logic        user;
        logic        wr;
        logic [31:0] ea;
        logic        hit;
        logic [31:0] raddr;
        logic        p_rd;
        logic        p_wr;
    } vec_t;

    localparam vec_t VEC [N_VEC] = '{
        '{1'b0, 1'b0, 1'b0, 32'h1234_5678, 1'b1, 32'h8234_5678, 1'b1, 1'b1}, // R4 R5 R6
        '{1'b1, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 32'h0,         1'b0, 1'b0}, // R2
        '{1'b0, 1'b0, 1'b0, 32'h2001_0004, 1'b0, 32'h0,         1'b0, 1'b0}, // R2
        '{1'b1, 1'b0, 1'b0, 32'h2001_0004, 1'b1, 32'h0A01_0004, 1'b1, 1'b0}, // R6
        '{1'b1, 1'b0, 1'b1, 32'h2001_0004, 1'b1, 32'h3001_0004, 1'b1, 1'b1}, // R7
        '{1'b1, 1'b1, 1'b0, 32'h2001_0004, 1'b1, 32'h3001_0004, 1'b1, 1'b1}, // R3
        '{1'b1, 1'b1, 1'b0, 32'h4000_0ABC, 1'b1, 32'h6666_0ABC, 1'b1, 1'b1}, // R7
        '{1'b1, 1'b0, 1'b0, 32'h7000_0123, 1'b1, 32'h0003_4123, 1'b1, 1'b1}, // R8
        '{1'b1, 1'b1, 1'b1, 32'h2FFF_FFFF, 1'b0, 32'h0,         1'b0, 1'b0}, // R9 R4
        '{1'b0, 1'b1, 1'b1, 32'h1FFF_FFFF, 1'b1, 32'h8FFF_FFFF, 1'b1, 1'b1}  // R5
    };

    task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic prog(input logic side, input logic [2:0] idx, input logic [31:0] base,
                        input logic [31:0] mask, input logic [31:0] rbase,
                        input logic uok, input logic sok, input logic [1:0] prot);
        @(negedge clk);
        cfg_we = 1'b1; cfg_side = side; cfg_idx = idx; cfg_base = base; cfg_mask = mask;
        cfg_rbase = rbase; cfg_user_ok = uok; cfg_sup_ok = sok; cfg_prot = prot;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request; leaves the response pending, sampled at negedge
    task automatic issue(input logic side, input logic user, input logic wr, input logic [31:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_data_side = side; req_user = user; req_write = wr; req_ea = ea;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic release_rsp();
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic lookup(input string tag, input vec_t v);
        issue(v.side, v.user, v.wr, v.ea);
        check({tag, " valid"}, rsp_valid === 1'b1, {31'b0, rsp_valid}, 32'h1);
        check({tag, " result"},
              rsp_hit === v.hit && rsp_raddr === v.raddr && rsp_rd === v.p_rd &&
              rsp_wr === v.p_wr && rsp_ex === v.hit,
              {rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_raddr[27:0]},
              {v.hit, v.p_rd, v.p_wr, v.hit, v.raddr[27:0]});
        release_rsp();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the handshake
        check("R1 ready", req_ready === 1'b1 && rsp_valid === 1'b0,
              {30'b0, req_ready, rsp_valid}, 32'h2);
        // R1: zeroed entries would match ea 0 if enabled; must miss
        lookup("R1 empty", '{1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0});
        lookup("R1 empty user", '{1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0});

        prog(1'b0, 3'd0, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 1'b1, 1'b1, 2'd2);
        prog(1'b1, 3'd0, 32'h2000_0000, 32'hFFF0_0000, 32'h0A00_0000, 1'b0, 1'b1, 2'd1);
        prog(1'b1, 3'd1, 32'h2000_0000, 32'hFF00_0000, 32'h3000_0000, 1'b1, 1'b1, 2'd3);
        prog(1'b1, 3'd2, 32'h4000_0000, 32'hFFFF_0000, 32'h5555_0000, 1'b1, 1'b0, 2'd0);
        prog(1'b1, 3'd3, 32'h4000_0000, 32'hFFFF_0000, 32'h6666_0000, 1'b1, 1'b1, 2'd2);
        prog(1'b1, 3'd4, 32'h7000_0000, 32'hFFFF_F000, 32'h0003_4000, 1'b1, 1'b1, 2'd2);
        prog(1'b1, 3'd5, 32'h7000_0000, 32'hFFFF_F000, 32'h0001_2000, 1'b1, 1'b1, 2'd2);

        for (int k = 0; k < N_VEC; k++) begin
            lookup($sformatf("vec%0d", k), VEC[k]);
        end

        // R10: response held while rsp_ready low
        issue(1'b0, 1'b0, 1'b0, 32'h1000_0040);
        @(negedge clk);
        @(negedge clk);
        check("R10 hold", rsp_valid === 1'b1 && req_ready === 1'b0 && rsp_raddr === 32'h8000_0040,
              rsp_raddr, 32'h8000_0040);
        release_rsp();
        check("R10 release", rsp_valid === 1'b0 && req_ready === 1'b1,
              {30'b0, req_ready, rsp_valid}, 32'h2);

        // R11: rewrite data entry 4 to code 0; entry 5 now serves (also R7)
        prog(1'b1, 3'd4, 32'h7000_0000, 32'hFFFF_F000, 32'h0003_4000, 1'b1, 1'b1, 2'd0);
        lookup("R11 rewrite", '{1'b1, 1'b0, 1'b0, 32'h7000_0123, 1'b1, 32'h0001_2123, 1'b1, 1'b1});
        // R11: instruction bank untouched by data-bank write
        lookup("R11 other bank", '{1'b0, 1'b0, 1'b0, 32'h1000_0000, 1'b1, 32'h8000_0000, 1'b1, 1'b1});
        // R7: read-only entry serves reads, user can't see supervisor-only entry 0
        lookup("R7 ro user wr", '{1'b1, 1'b1, 1'b1, 32'h2000_0010, 1'b1, 32'h3000_0010, 1'b1, 1'b1});

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule